// File: doc/BRIEF.md
# Jitter Tolerance Error-Onset Search Controller

This block drives the amplitude code of a jitter generator and finds the largest sinusoidal jitter amplitude that a receiver under test can take at one jitter frequency before errors set in. It watches a per-bit error strobe from an external pattern checker and a one-second timebase tick, and turns them into errored seconds. An errored second is a one-second interval that holds at least one bit error.

The search runs in two phases. In the coarse phase the amplitude climbs in large steps, one tick per step, until a second shows errors. That marks the transition region. The controller then steps back to the last clean coarse amplitude and starts the fine phase. In the fine phase the amplitude climbs in small steps, and each step is held for a 30-second window. Errored seconds are summed across all fine windows. The reported tolerance is the last amplitude whose running total stayed at two or fewer.

If the first fine window shows any error, the start point was not clean, and the controller reports a setup fault. If the amplitude reaches the configured ceiling with no failure, the ceiling is reported together with a saturation flag.

Top module: `jtol_search_ctrl`

## Requirements
- R1: A one-cycle start_i pulse while idle clears all results and counters, sets busy_o, and puts amplitude code 0 on amp_code_o.
- R2: A second, which ends at a sec_tick_i cycle, counts as one errored second if err_strobe_i was high on any cycle within it, including the tick cycle itself. It counts as one errored second no matter how many strobes it holds.
- R3: In the coarse phase, each error-free second raises amp_code_o by coarse_step_i, clamped to amp_max_i. The new value appears on the cycle after the tick.
- R4: The first errored second of the coarse phase starts the fine phase at the last error-free coarse amplitude. That amplitude is 0 if the first coarse second already had errors.
- R5: In the fine phase, each completed 30-tick window that does not stop the search raises amp_code_o by fine_step_i, clamped to amp_max_i.
- R6: Any errored second inside the first fine window stops the search at once, with setup_fault_o=1 and tol_amp_o=0.
- R7: Errored seconds are summed across fine windows. At the tick where the total reaches 3, the search stops at once and tol_amp_o takes the amplitude of the previous fine step.
- R8: An error-free coarse second at amp_max_i, or a completed fine window at amp_max_i without a stop, ends the search with tol_amp_o=amp_max_i and sat_o=1.
- R9: At every stop, done_o is high for exactly one cycle and busy_o goes low. amp_code_o returns to 0, and tol_amp_o, sat_o and setup_fault_o hold until the next start.
- R10: Error strobes while idle have no effect on any output, and none of them is counted in the next search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a search (accepted while idle) |
| err_strobe_i | input | 1 | One-cycle pulse per detected bit error |
| sec_tick_i | input | 1 | One-cycle pulse ending each second |
| coarse_step_i | input | AMP_W | Coarse amplitude increment |
| fine_step_i | input | AMP_W | Fine amplitude increment |
| amp_max_i | input | AMP_W | Amplitude ceiling |
| amp_code_o | output | AMP_W | Amplitude code for the jitter generator |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse at the end of a search |
| tol_amp_o | output | AMP_W | Tolerated amplitude result |
| sat_o | output | 1 | Ceiling reached without failure |
| setup_fault_o | output | 1 | First fine window was not clean |

## Verification
The hardest state to reach from the ports is the cumulative stop. That stop needs errored seconds spread over more than one fine window, and it needs them after a first fine window that was fully clean. The stimulus gets there by sending exactly 30 clean ticks and then a window with two errored seconds. One of those seconds holds several strobes, so that a design counting strobes instead of seconds would stop too early. A single error in the following window must then stop the search and report the previous step. Separate runs start the fine phase from amplitude zero and place a strobe on the tick cycle itself, which checks that a boundary error is counted and raises the setup fault.

// File: rtl/jtol_pkg.sv
package jtol_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COARSE = 2'd1,
        ST_FINE   = 2'd2
    } jtol_state_e;

    typedef struct packed {
        logic sat;
        logic fault;
    } jtol_flags_t;

endpackage

// File: rtl/jtol_es_detect.sv
module jtol_es_detect (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic en_i,
    input  logic err_i,
    input  logic tick_i,
    output logic es_o
);
    logic seen_q;

    assign es_o = tick_i & en_i & (seen_q | err_i);

    always_ff @(posedge clk) begin
        if (rst || clr_i || tick_i) begin
            seen_q <= 1'b0;
        end else if (en_i && err_i) begin
            seen_q <= 1'b1;
        end
    end

    // R2: the per-second error memory is always empty after a tick
    a_r2_clear_at_tick: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> !seen_q);
    // R10: nothing is remembered while disabled
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !seen_q) |=> !seen_q);
endmodule

// File: rtl/jtol_win_timer.sv
module jtol_win_timer #(
    parameter int WIN_SECS = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic en_i,
    input  logic tick_i,
    output logic win_end_o
);
    localparam int CW = (WIN_SECS > 1) ? $clog2(WIN_SECS) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN_SECS - 1);

    logic [CW-1:0] cnt_q;

    assign win_end_o = en_i & tick_i & (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (en_i && tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // R5: the window count never passes its final second
    a_r5_win_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
endmodule

// File: rtl/jtol_seq.sv
module jtol_seq
    import jtol_pkg::*;
#(
    parameter int AMP_W   = 8,
    parameter int ES_FAIL = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic             es_i,
    input  logic             win_end_i,
    input  logic [AMP_W-1:0] coarse_step_i,
    input  logic [AMP_W-1:0] fine_step_i,
    input  logic [AMP_W-1:0] amp_max_i,
    output logic [AMP_W-1:0] amp_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [AMP_W-1:0] tol_o,
    output logic             sat_o,
    output logic             fault_o,
    output logic             fine_o,
    output logic             clr_o
);
    localparam int ESW = $clog2(ES_FAIL + 1);
    localparam logic [ESW-1:0] ES_LAST = ESW'(ES_FAIL - 1);

    jtol_state_e      st_q;
    logic [AMP_W-1:0] amp_q, prev_q, tol_q;
    logic [ESW-1:0]   cum_q;
    logic             first_q, done_q;
    jtol_flags_t      flg_q;

    function automatic logic [AMP_W-1:0] step_up(
        input logic [AMP_W-1:0] a, input logic [AMP_W-1:0] s,
        input logic [AMP_W-1:0] m);
        logic [AMP_W:0] sum;
        sum = {1'b0, a} + {1'b0, s};
        step_up = (sum > {1'b0, m}) ? m : sum[AMP_W-1:0];
    endfunction

    assign amp_o   = amp_q;
    assign busy_o  = (st_q != ST_IDLE);
    assign done_o  = done_q;
    assign tol_o   = tol_q;
    assign sat_o   = flg_q.sat;
    assign fault_o = flg_q.fault;
    assign fine_o  = (st_q == ST_FINE);
    assign clr_o   = ((st_q == ST_IDLE) && start_i) ||
                     ((st_q == ST_COARSE) && tick_i && es_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            amp_q   <= '0;
            prev_q  <= '0;
            tol_q   <= '0;
            cum_q   <= '0;
            first_q <= 1'b0;
            done_q  <= 1'b0;
            flg_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        st_q    <= ST_COARSE;
                        amp_q   <= '0;
                        prev_q  <= '0;
                        tol_q   <= '0;
                        cum_q   <= '0;
                        first_q <= 1'b1;
                        flg_q   <= '0;
                    end
                end
                ST_COARSE: begin
                    if (tick_i) begin
                        if (es_i) begin
                            st_q    <= ST_FINE;
                            amp_q   <= prev_q;
                            cum_q   <= '0;
                            first_q <= 1'b1;
                        end else if (amp_q == amp_max_i) begin
                            st_q      <= ST_IDLE;
                            done_q    <= 1'b1;
                            tol_q     <= amp_q;
                            flg_q.sat <= 1'b1;
                            amp_q     <= '0;
                        end else begin
                            prev_q <= amp_q;
                            amp_q  <= step_up(amp_q, coarse_step_i, amp_max_i);
                        end
                    end
                end
                ST_FINE: begin
                    if (tick_i) begin
                        if (es_i && first_q) begin
                            st_q        <= ST_IDLE;
                            done_q      <= 1'b1;
                            tol_q       <= '0;
                            flg_q.fault <= 1'b1;
                            amp_q       <= '0;
                        end else if (es_i && (cum_q == ES_LAST)) begin
                            st_q   <= ST_IDLE;
                            done_q <= 1'b1;
                            tol_q  <= prev_q;
                            amp_q  <= '0;
                        end else begin
                            if (es_i) cum_q <= cum_q + 1'b1;
                            if (win_end_i) begin
                                if (amp_q == amp_max_i) begin
                                    st_q      <= ST_IDLE;
                                    done_q    <= 1'b1;
                                    tol_q     <= amp_q;
                                    flg_q.sat <= 1'b1;
                                    amp_q     <= '0;
                                end else begin
                                    prev_q  <= amp_q;
                                    amp_q   <= step_up(amp_q, fine_step_i, amp_max_i);
                                    first_q <= 1'b0;
                                end
                            end
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    // R9: no amplitude is applied while idle
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> (amp_q == '0));
    // R7: the running total never reaches the failing count while searching
    a_r7_cum_bound: assert property (@(posedge clk) disable iff (rst)
        cum_q < ESW'(ES_FAIL));
    // R5: fine amplitude never decreases within a fine phase
    a_r5_fine_monotone: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_FINE) && ($past(st_q) == ST_FINE)) |-> (amp_q >= $past(amp_q)));
    // R6: a fault and saturation are never reported together
    a_r6_fault_excl: assert property (@(posedge clk) disable iff (rst)
        !(flg_q.fault && flg_q.sat));
endmodule

// File: rtl/jtol_search_ctrl.sv
module jtol_search_ctrl #(
    parameter int AMP_W    = 8,
    parameter int WIN_SECS = 30,
    parameter int ES_FAIL  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             err_strobe_i,
    input  logic             sec_tick_i,
    input  logic [AMP_W-1:0] coarse_step_i,
    input  logic [AMP_W-1:0] fine_step_i,
    input  logic [AMP_W-1:0] amp_max_i,
    output logic [AMP_W-1:0] amp_code_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [AMP_W-1:0] tol_amp_o,
    output logic             sat_o,
    output logic             setup_fault_o
);
    logic es, win_end, fine, clr;

    jtol_es_detect u_es (
        .clk(clk), .rst(rst), .clr_i(clr), .en_i(busy_o),
        .err_i(err_strobe_i), .tick_i(sec_tick_i), .es_o(es)
    );

    jtol_win_timer #(.WIN_SECS(WIN_SECS)) u_win (
        .clk(clk), .rst(rst), .clr_i(clr), .en_i(fine),
        .tick_i(sec_tick_i), .win_end_o(win_end)
    );

    jtol_seq #(.AMP_W(AMP_W), .ES_FAIL(ES_FAIL)) u_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .tick_i(sec_tick_i),
        .es_i(es), .win_end_i(win_end), .coarse_step_i(coarse_step_i),
        .fine_step_i(fine_step_i), .amp_max_i(amp_max_i),
        .amp_o(amp_code_o), .busy_o(busy_o), .done_o(done_o),
        .tol_o(tol_amp_o), .sat_o(sat_o), .fault_o(setup_fault_o),
        .fine_o(fine), .clr_o(clr)
    );
endmodule

// File: tb/tb_jtol_search_ctrl.sv
module tb_jtol_search_ctrl;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, err = 1'b0, tick = 1'b0;
    logic [AW-1:0] cstep = '0, fstep = '0, amax = '0;
    logic [AW-1:0] amp, tol;
    logic busy, done, sat, fault;
    int n_chk = 0, n_bad = 0, cyc = 0;

    always #2.5 clk = ~clk;

    jtol_search_ctrl #(.AMP_W(AW)) dut (
        .clk(clk), .rst(rst), .start_i(start), .err_strobe_i(err),
        .sec_tick_i(tick), .coarse_step_i(cstep), .fine_step_i(fstep),
        .amp_max_i(amax), .amp_code_o(amp), .busy_o(busy), .done_o(done),
        .tol_amp_o(tol), .sat_o(sat), .setup_fault_o(fault)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy, 1, "R1 busy after start");
        chk(amp, 0, "R1 amp after start");
        chk(sat | fault, 0, "R1 flags cleared");
    endtask

    // one second: nerr strobe cycles, then the tick (strobe on tick if co)
    task automatic sec(input int nerr, input bit co);
        for (int i = 0; i < nerr; i++) begin
            @(negedge clk) err = 1'b1;
            @(negedge clk) err = 1'b0;
        end
        @(negedge clk) begin tick = 1'b1; err = co; end
        @(negedge clk) begin tick = 1'b0; err = 1'b0; end
    endtask

    task automatic clean_secs(input int n);
        for (int i = 0; i < n; i++) sec(0, 1'b0);
    endtask

    task automatic t_reset();
        chk(amp, 0, "R9 reset amp");
        chk(busy, 0, "R9 reset busy");
        chk(done, 0, "R9 reset done");
        chk(tol, 0, "R9 reset tol");
    endtask

    task automatic t_idle_strobes();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk) err = 1'b1;
            @(negedge clk) err = 1'b0;
            chk(busy | done | amp, 0, "R10 idle strobe no effect");
        end
        cstep = 8'd20; fstep = 8'd1; amax = 8'd200;
        do_start();
        sec(0, 1'b0);
        chk(amp, 20, "R10 idle strobes not counted");
        sec(1, 1'b0);
        chk(amp, 0, "R4 fine from last clean coarse amp 0");
        sec(1, 1'b0);
        chk(fault, 1, "R6 fault");
        chk(done, 1, "R9 done pulse");
    endtask

    task automatic t_cumulative();
        cstep = 8'd16; fstep = 8'd2; amax = 8'd200;
        do_start();
        sec(0, 1'b0); chk(amp, 16, "R3 coarse step 1");
        sec(0, 1'b0); chk(amp, 32, "R3 coarse step 2");
        sec(0, 1'b0); chk(amp, 48, "R3 coarse step 3");
        sec(2, 1'b0); chk(amp, 32, "R4 back to last clean coarse");
        clean_secs(29); chk(amp, 32, "R5 window not yet over");
        sec(0, 1'b0); chk(amp, 34, "R5 fine step after 30 ticks");
        sec(3, 1'b0);
        clean_secs(5);
        sec(0, 1'b1);
        chk(busy, 1, "R2 two errored seconds do not stop");
        clean_secs(23); chk(amp, 36, "R2 multi-strobe second counted once");
        clean_secs(4);
        sec(1, 1'b0);
        chk(done, 1, "R7 stop on third errored second");
        chk(tol, 34, "R7 previous fine amplitude");
        chk(sat | fault, 0, "R7 no sat/fault");
        chk(busy, 0, "R9 busy low at stop");
        chk(amp, 0, "R9 amp zero at stop");
        @(negedge clk);
        chk(done, 0, "R9 done lasts one cycle");
        chk(tol, 34, "R9 tol held");
    endtask

    task automatic t_coarse_sat();
        cstep = 8'd100; fstep = 8'd1; amax = 8'd250;
        do_start();
        sec(0, 1'b0); sec(0, 1'b0);
        sec(0, 1'b0); chk(amp, 250, "R3 coarse clamp to max");
        sec(0, 1'b0);
        chk(done, 1, "R8 coarse saturation done");
        chk(sat, 1, "R8 sat flag");
        chk(tol, 250, "R8 tol is max");
    endtask

    task automatic t_setup_fault();
        cstep = 8'd10; fstep = 8'd1; amax = 8'd200;
        do_start();
        chk(tol, 0, "R1 tol cleared by start");
        chk(sat, 0, "R1 sat cleared by start");
        sec(0, 1'b0); sec(0, 1'b0);
        sec(1, 1'b0); chk(amp, 10, "R4 fine start at 10");
        clean_secs(5);
        sec(0, 1'b1);
        chk(done, 1, "R6 fault stop");
        chk(fault, 1, "R6 fault flag (strobe on tick, R2)");
        chk(tol, 0, "R6 tol zero");
    endtask

    task automatic t_fine_sat();
        cstep = 8'd16; fstep = 8'd8; amax = 8'd40;
        do_start();
        sec(0, 1'b0); sec(0, 1'b0);
        sec(0, 1'b0); chk(amp, 40, "R3 clamp at 40");
        sec(1, 1'b0); chk(amp, 32, "R4 fine from 32");
        clean_secs(30); chk(amp, 40, "R5 fine clamp");
        clean_secs(29); chk(busy, 1, "R8 not yet saturated");
        sec(0, 1'b0);
        chk(done, 1, "R8 fine saturation done");
        chk(sat, 1, "R8 fine sat flag");
        chk(tol, 40, "R8 fine tol max");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle_strobes();
        t_cumulative();
        t_coarse_sat();
        t_setup_fault();
        t_fine_sat();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule